// File: doc/BRIEF.md
# Host-to-PCI Request Translator

This block sits between two request sources, a CPU-side port and a hub-side port, and a PCI-style initiator bus. For every request it chooses a destination and a command code. Memory, configuration and in-window I/O requests become PCI beats. CPU I/O outside a programmable window goes back out on a forward port towards the hub. Requests that address 4 GB or more, or that carry a reserved kind, are answered with a one-cycle error pulse. Lock requests are dropped, so every PCI transaction leaves unlocked. Configuration requests are sent as Type 1 cycles.

Back-to-back CPU memory writes to ascending, adjacent dword addresses are gathered into one PCI burst of at most `MAX_BEATS` dwords. Two writes to the same address are never folded into one beat. The PCI side receives one beat per cycle on a valid/ready handshake. Each beat carries a command, the dword address, active-high byte enables and a last flag. The bus signalling below this, target retries and the register file that holds the I/O window all lie outside the block. The window bounds arrive on input ports.

Request kind encoding, on 3 bits: 0 memory read, 1 memory write, 2 I/O read, 3 I/O write, 4 configuration read, 5 configuration write, 6 and 7 reserved. A request of either size has dword-aligned addresses. In a qword request, byte enables [3:0] belong to the lower dword and [7:4] to the upper. A dword request uses only [3:0].

Top module: `host_pci_xlate`

## Requirements
- R1: A memory read from either port produces PCI beats with command 4'b0110. A dword read gives one beat and a qword read gives two beats (address, then address+4), with byte enables [3:0] followed by [7:4].
- R2: Memory writes leave with command 4'b0111. Command 4'b1111 is never issued.
- R3: A CPU I/O request (kinds 2/3) whose address is below 2^16 and lies in io_base..io_limit, both bounds inclusive, leaves on PCI with command 4'b0010 (read) or 4'b0011 (write). Any other CPU I/O request appears on the forward port with its kind, full address, all eight byte enables, size and lock bit unchanged. Hub I/O requests always go to PCI.
- R4: The lock input has no effect on PCI output. A locked request yields exactly the beats its unlocked twin would.
- R5: Configuration requests leave as Type 1 cycles: command 4'b1010 (read) or 4'b1011 (write), with address bits [1:0] = 2'b01 and bits [31:2] taken from the request.
- R6: A request with any address bit at or above bit 32 set, or with kind 6 or 7, is accepted but produces no PCI beat. The requesting port's error output (cpu_err or hub_err) goes high for one cycle, in the cycle after acceptance.
- R7: A CPU memory write joins the open burst only if it is presented in the cycle right after the previous write was accepted, and its address equals the previous address plus the previous size. A write to the same address, a gap or any other request closes the burst first.
- R8: A burst never exceeds 8 beats. A write that would take it past 8 starts a new burst, and a burst that reaches exactly 8 closes at once.
- R9: Hub memory writes are never combined. Each leaves as its own Memory Write burst.
- R10: When both ports request in the same cycle, the CPU is served first. A hub request arriving while a CPU burst is open waits until that burst has been emitted.
- R11: After reset no PCI, forward or error output is active. While pci_valid is high and pci_ready low, all PCI outputs hold. Beat k of a burst carries start address + 4k, and pci_last is set only on the final beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_base | input | IO_W | Lowest I/O address routed to PCI |
| io_limit | input | IO_W | Highest I/O address routed to PCI |
| cpu_req_valid | input | 1 | CPU request present |
| cpu_req_ready | output | 1 | CPU request taken this cycle |
| cpu_req_kind | input | 3 | CPU request kind |
| cpu_req_addr | input | ADDR_W | CPU byte address |
| cpu_req_qword | input | 1 | CPU request is a qword |
| cpu_req_lock | input | 1 | CPU request asks for a lock |
| cpu_req_be | input | 8 | CPU byte enables |
| cpu_err | output | 1 | CPU request rejected |
| hub_req_valid | input | 1 | Hub request present |
| hub_req_ready | output | 1 | Hub request taken this cycle |
| hub_req_kind | input | 3 | Hub request kind |
| hub_req_addr | input | ADDR_W | Hub byte address |
| hub_req_qword | input | 1 | Hub request is a qword |
| hub_req_lock | input | 1 | Hub request asks for a lock |
| hub_req_be | input | 8 | Hub byte enables |
| hub_err | output | 1 | Hub request rejected |
| pci_valid | output | 1 | PCI beat present |
| pci_ready | input | 1 | PCI beat consumed |
| pci_cmd | output | 4 | PCI command code |
| pci_addr | output | 32 | Dword address of this beat |
| pci_be | output | 4 | Byte enables of this beat, active high |
| pci_last | output | 1 | Final beat of the burst |
| fwd_valid | output | 1 | Request forwarded towards hub |
| fwd_ready | input | 1 | Forwarded request taken |
| fwd_kind | output | 3 | Forwarded kind |
| fwd_addr | output | ADDR_W | Forwarded address |
| fwd_qword | output | 1 | Forwarded size |
| fwd_lock | output | 1 | Forwarded lock bit |
| fwd_be | output | 8 | Forwarded byte enables |

## Verification
The hardest case to reach is the edge of the write-combining window. That means a burst filling to exactly eight beats, a qword arriving at seven, and a hub request that shows up while a CPU burst is still open. The bench gets there by making the CPU request task present the next write in the very cycle after the previous one is accepted. It sweeps run lengths from one to ten dwords and one to five qwords, and forks a hub requester against a CPU write run. The I/O window is swept one dword at a time across both bounds, and the combining sweeps are repeated with a stalling PCI ready.

// File: rtl/host_pci_xlate.sv
module host_pci_xlate #(
  parameter int ADDR_W    = 36,
  parameter int IO_W      = 16,
  parameter int MAX_BEATS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IO_W-1:0]   io_base,
  input  logic [IO_W-1:0]   io_limit,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic [2:0]        cpu_req_kind,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic              cpu_req_qword,
  input  logic              cpu_req_lock,
  input  logic [7:0]        cpu_req_be,
  output logic              cpu_err,
  input  logic              hub_req_valid,
  output logic              hub_req_ready,
  input  logic [2:0]        hub_req_kind,
  input  logic [ADDR_W-1:0] hub_req_addr,
  input  logic              hub_req_qword,
  input  logic              hub_req_lock,
  input  logic [7:0]        hub_req_be,
  output logic              hub_err,
  output logic              pci_valid,
  input  logic              pci_ready,
  output logic [3:0]        pci_cmd,
  output logic [31:0]       pci_addr,
  output logic [3:0]        pci_be,
  output logic              pci_last,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  output logic [2:0]        fwd_kind,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic              fwd_qword,
  output logic              fwd_lock,
  output logic [7:0]        fwd_be
);
  localparam int CW = $clog2(MAX_BEATS + 3);
  localparam int IW = $clog2(MAX_BEATS);

  logic              use_cpu, sel_valid, sel_qword, sel_lock;
  logic [2:0]        sel_kind;
  logic [ADDR_W-1:0] sel_addr;
  logic [7:0]        sel_be;

  assign use_cpu   = cpu_req_valid;
  assign sel_valid = cpu_req_valid | hub_req_valid;
  assign sel_kind  = use_cpu ? cpu_req_kind  : hub_req_kind;
  assign sel_addr  = use_cpu ? cpu_req_addr  : hub_req_addr;
  assign sel_qword = use_cpu ? cpu_req_qword : hub_req_qword;
  assign sel_lock  = use_cpu ? cpu_req_lock  : hub_req_lock;
  assign sel_be    = use_cpu ? cpu_req_be    : hub_req_be;

  logic reject, is_io, io_hit, to_fwd, cpu_wr;
  assign reject = (|sel_addr[ADDR_W-1:32]) | (sel_kind[2:1] == 2'b11);
  assign is_io  = sel_kind[2:1] == 2'b01;
  assign io_hit = ~|sel_addr[ADDR_W-1:IO_W] &&
                  sel_addr[IO_W-1:0] >= io_base && sel_addr[IO_W-1:0] <= io_limit;
  assign to_fwd = use_cpu && is_io && !io_hit && !reject;
  assign cpu_wr = use_cpu && sel_kind == 3'd1 && !reject;

  logic [3:0]  sel_cmd;
  logic [31:0] sel_start;
  always_comb begin
    case (sel_kind)
      3'd0:    sel_cmd = 4'b0110;
      3'd1:    sel_cmd = 4'b0111;
      3'd2:    sel_cmd = 4'b0010;
      3'd3:    sel_cmd = 4'b0011;
      3'd4:    sel_cmd = 4'b1010;
      3'd5:    sel_cmd = 4'b1011;
      default: sel_cmd = 4'b0000;
    endcase
  end
  assign sel_start = {sel_addr[31:2], (sel_kind[2:1] == 2'b10) ? 2'b01 : 2'b00};

  logic          drain, open;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic [31:0]   b_addr;
  logic [3:0]    b_cmd;
  logic [3:0]    b_be [MAX_BEATS];

  logic          idle, seq_hit, fits, can_join, take_new, accept, beat_last;
  logic [CW-1:0] nbeats, base, new_cnt;

  assign idle     = !drain && !open;
  assign nbeats   = sel_qword ? CW'(2) : CW'(1);
  assign base     = idle ? CW'(0) : cnt;
  assign new_cnt  = base + nbeats;
  assign fits     = new_cnt <= CW'(MAX_BEATS);
  assign seq_hit  = {sel_addr[31:2], 2'b00} == b_addr + 32'({cnt, 2'b00});
  assign can_join = open && cpu_wr && seq_hit && fits;
  assign take_new = idle && sel_valid && !reject && !to_fwd;
  assign accept   = sel_valid && ((idle && (reject || !to_fwd || fwd_ready)) || can_join);
  assign beat_last = (CW'(idx) + CW'(1)) == cnt;

  assign cpu_req_ready = accept && use_cpu;
  assign hub_req_ready = accept && !use_cpu;

  assign fwd_valid = idle && to_fwd;
  assign fwd_kind  = sel_kind;
  assign fwd_addr  = sel_addr;
  assign fwd_qword = sel_qword;
  assign fwd_lock  = sel_lock;
  assign fwd_be    = sel_be;

  assign pci_valid = drain;
  assign pci_cmd   = b_cmd;
  assign pci_addr  = b_addr + 32'({idx, 2'b00});
  assign pci_be    = b_be[idx];
  assign pci_last  = drain && beat_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drain   <= 1'b0;
      open    <= 1'b0;
      cnt     <= '0;
      idx     <= '0;
      b_addr  <= '0;
      b_cmd   <= '0;
      cpu_err <= 1'b0;
      hub_err <= 1'b0;
      for (int i = 0; i < MAX_BEATS; i++) b_be[i] <= '0;
    end else begin
      cpu_err <= accept && reject && use_cpu;
      hub_err <= accept && reject && !use_cpu;
      if (drain) begin
        if (pci_ready) begin
          if (beat_last) begin
            drain <= 1'b0;
            cnt   <= '0;
            idx   <= '0;
          end else begin
            idx <= idx + IW'(1);
          end
        end
      end else if (take_new || can_join) begin
        if (take_new) begin
          b_addr <= sel_start;
          b_cmd  <= sel_cmd;
        end
        cnt <= new_cnt;
        for (int i = 0; i < MAX_BEATS; i++) begin
          if (CW'(i) == base) b_be[i] <= sel_be[3:0];
          if (sel_qword && CW'(i) == base + CW'(1)) b_be[i] <= sel_be[7:4];
        end
        if (cpu_wr && new_cnt < CW'(MAX_BEATS)) begin
          open <= 1'b1;
        end else begin
          open  <= 1'b0;
          drain <= 1'b1;
        end
      end else if (open) begin
        open  <= 1'b0;
        drain <= 1'b1;
      end
    end
  end
endmodule

module host_pci_xlate_chk #(
  parameter int ADDR_W    = 36,
  parameter int IO_W      = 16,
  parameter int MAX_BEATS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [IO_W-1:0]   io_base,
  input logic [IO_W-1:0]   io_limit,
  input logic              cpu_req_valid,
  input logic              cpu_req_ready,
  input logic [2:0]        cpu_req_kind,
  input logic [ADDR_W-1:0] cpu_req_addr,
  input logic              cpu_err,
  input logic              hub_req_ready,
  input logic              pci_valid,
  input logic              pci_ready,
  input logic [3:0]        pci_cmd,
  input logic [31:0]       pci_addr,
  input logic [3:0]        pci_be,
  input logic              pci_last,
  input logic              fwd_valid
);
  localparam int BW = $clog2(MAX_BEATS + 1);
  logic [BW-1:0] beats;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beats <= '0;
    else if (pci_valid && pci_ready) beats <= pci_last ? '0 : beats + BW'(1);
  end

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pci_valid && !pci_ready |=> pci_valid && $stable(pci_cmd) && $stable(pci_addr)
                                && $stable(pci_be) && $stable(pci_last));

  p_no_mwi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pci_valid |-> pci_cmd != 4'b1111);

  p_type1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pci_valid && pci_cmd[3:1] == 3'b101 |-> pci_addr[1:0] == 2'b01);

  p_err_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_err |-> $past(cpu_req_valid && cpu_req_ready &&
                      ((|cpu_req_addr[ADDR_W-1:32]) || cpu_req_kind[2:1] == 2'b11)));

  p_cpu_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_valid |-> !hub_req_ready);

  p_fwd_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> cpu_req_valid && cpu_req_kind[2:1] == 2'b01 &&
                  !(~|cpu_req_addr[ADDR_W-1:IO_W] && cpu_req_addr[IO_W-1:0] >= io_base &&
                    cpu_req_addr[IO_W-1:0] <= io_limit));

  p_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pci_valid |-> beats < BW'(MAX_BEATS));

  p_cap_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pci_valid && beats == BW'(MAX_BEATS - 1) |-> pci_last);
endmodule

bind host_pci_xlate host_pci_xlate_chk #(
  .ADDR_W(ADDR_W), .IO_W(IO_W), .MAX_BEATS(MAX_BEATS)
) u_chk (.*);

// File: tb/host_pci_xlate_bench.sv
module host_pci_xlate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [15:0] io_base = 16'h0100, io_limit = 16'h010C;
  logic cpu_req_valid = 0, cpu_req_qword = 0, cpu_req_lock = 0;
  logic [2:0] cpu_req_kind = 0;
  logic [AW-1:0] cpu_req_addr = 0;
  logic [7:0] cpu_req_be = 0;
  logic hub_req_valid = 0, hub_req_qword = 0, hub_req_lock = 0;
  logic [2:0] hub_req_kind = 0;
  logic [AW-1:0] hub_req_addr = 0;
  logic [7:0] hub_req_be = 0;
  logic cpu_req_ready, hub_req_ready, cpu_err, hub_err;
  logic pci_valid, pci_ready, pci_last;
  logic [3:0] pci_cmd, pci_be;
  logic [31:0] pci_addr;
  logic fwd_valid, fwd_ready, fwd_qword, fwd_lock;
  logic [2:0] fwd_kind;
  logic [AW-1:0] fwd_addr;
  logic [7:0] fwd_be;

  logic stall = 1'b0;
  logic [7:0] cyc = 8'd0;
  always_ff @(posedge clk) cyc <= cyc + 8'd1;
  assign pci_ready = !stall || cyc[1:0] != 2'b00;
  assign fwd_ready = !stall || cyc[0];

  host_pci_xlate u_host_pci_xlate (.*);

  int checks = 0, failures = 0, cpu_errs = 0, hub_errs = 0;
  logic [40:0] got_q[$], exp_q[$];
  logic [48:0] got_f[$], exp_f[$];

  always @(negedge clk) if (rst_n) begin
    if (pci_valid && pci_ready) got_q.push_back({pci_cmd, pci_addr, pci_be, pci_last});
    if (fwd_valid && fwd_ready) got_f.push_back({fwd_kind, fwd_addr, fwd_be, fwd_qword, fwd_lock});
    if (cpu_err) cpu_errs++;
    if (hub_err) hub_errs++;
  end

  task automatic eb(input logic [3:0] c, input logic [31:0] a, input logic [3:0] b, input logic l);
    exp_q.push_back({c, a, b, l});
  endtask

  task automatic cpu_send(input logic [2:0] k, input logic [AW-1:0] a, input logic q,
                          input logic lk, input logic [7:0] b);
    cpu_req_valid = 1; cpu_req_kind = k; cpu_req_addr = a;
    cpu_req_qword = q; cpu_req_lock = lk; cpu_req_be = b;
    forever begin @(negedge clk); if (cpu_req_ready) break; end
    @(posedge clk); #1;
    cpu_req_valid = 0;
  endtask

  task automatic hub_send(input logic [2:0] k, input logic [AW-1:0] a, input logic q,
                          input logic lk, input logic [7:0] b);
    hub_req_valid = 1; hub_req_kind = k; hub_req_addr = a;
    hub_req_qword = q; hub_req_lock = lk; hub_req_be = b;
    forever begin @(negedge clk); if (hub_req_ready) break; end
    @(posedge clk); #1;
    hub_req_valid = 0;
  endtask

  task automatic gap(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check_out(input string tag);
    gap(40);
    checks++;
    if (got_q.size() != exp_q.size()) begin
      failures++;
      $display("FAIL %s: pci beats got %0d expected %0d", tag, got_q.size(), exp_q.size());
    end
    for (int i = 0; i < exp_q.size(); i++) begin
      checks++;
      if (i >= got_q.size() || got_q[i] !== exp_q[i]) begin
        failures++;
        $display("FAIL %s: beat %0d got %h expected %h", tag, i,
                 (i < got_q.size()) ? got_q[i] : 41'h0, exp_q[i]);
      end
    end
    checks++;
    if (got_f.size() != exp_f.size()) begin
      failures++;
      $display("FAIL %s: forwards got %0d expected %0d", tag, got_f.size(), exp_f.size());
    end
    for (int i = 0; i < exp_f.size(); i++) begin
      checks++;
      if (i >= got_f.size() || got_f[i] !== exp_f[i]) begin
        failures++;
        $display("FAIL %s: forward %0d got %h expected %h", tag, i,
                 (i < got_f.size()) ? got_f[i] : 49'h0, exp_f[i]);
      end
    end
    got_q.delete(); exp_q.delete(); got_f.delete(); exp_f.delete();
  endtask

  task automatic check_err(input string tag, input int ec, input int eh);
    checks++;
    if (cpu_errs != ec || hub_errs != eh) begin
      failures++;
      $display("FAIL %s: err pulses cpu=%0d hub=%0d expected cpu=%0d hub=%0d",
               tag, cpu_errs, hub_errs, ec, eh);
    end
    cpu_errs = 0; hub_errs = 0;
  endtask

  task automatic wr_sweep(input string tag, input bit qw);
    for (int n = 1; n <= (qw ? 5 : 10); n++) begin
      logic [31:0] a0;
      int beats;
      a0 = 32'h0001_0000 * n;
      beats = qw ? 2 * n : n;
      for (int j = 0; j < n; j++) begin
        if (qw) cpu_send(3'd1, AW'(a0 + 8 * j), 1'b1, 1'b0, {4'(2 * j + 2), 4'(2 * j + 1)});
        else    cpu_send(3'd1, AW'(a0 + 4 * j), 1'b0, 1'b0, {4'h0, 4'(j + 1)});
      end
      for (int i = 0; i < beats; i++)
        eb(4'b0111, a0 + 4 * i, 4'(i + 1), (i % 8 == 7) || (i == beats - 1));
      check_out(tag);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    checks++;
    if (pci_valid !== 0 || fwd_valid !== 0 || cpu_err !== 0 || hub_err !== 0) begin
      failures++;
      $display("FAIL R11 reset: pci=%b fwd=%b errs=%b%b expected 0000",
               pci_valid, fwd_valid, cpu_err, hub_err);
    end

    cpu_send(3'd0, 36'h1000, 1'b0, 1'b0, 8'h0F);
    cpu_send(3'd0, 36'h2000, 1'b1, 1'b0, 8'h3C);
    hub_send(3'd0, 36'h2100, 1'b0, 1'b0, 8'h05);
    eb(4'b0110, 32'h1000, 4'hF, 1);
    eb(4'b0110, 32'h2000, 4'hC, 0); eb(4'b0110, 32'h2004, 4'h3, 1);
    eb(4'b0110, 32'h2100, 4'h5, 1);
    check_out("R1 reads");

    cpu_send(3'd0, 36'h3000, 1'b0, 1'b1, 8'h0F);
    cpu_send(3'd0, 36'h3000, 1'b0, 1'b0, 8'h0F);
    hub_send(3'd1, 36'h3100, 1'b0, 1'b1, 8'h0A);
    eb(4'b0110, 32'h3000, 4'hF, 1); eb(4'b0110, 32'h3000, 4'hF, 1);
    eb(4'b0111, 32'h3100, 4'hA, 1);
    check_out("R4 lock stripped");

    wr_sweep("R7 R8 R2 dword runs", 1'b0);
    wr_sweep("R7 R8 qword runs", 1'b1);

    for (int j = 0; j < 7; j++) cpu_send(3'd1, AW'(32'h4000 + 4 * j), 1'b0, 1'b0, 8'h01);
    cpu_send(3'd1, 36'h401C, 1'b1, 1'b0, 8'h21);
    for (int i = 0; i < 7; i++) eb(4'b0111, 32'h4000 + 4 * i, 4'h1, i == 6);
    eb(4'b0111, 32'h401C, 4'h1, 0); eb(4'b0111, 32'h4020, 4'h2, 1);
    check_out("R8 qword overflow at seven");

    cpu_send(3'd1, 36'h5000, 1'b0, 1'b0, 8'h01);
    cpu_send(3'd1, 36'h5000, 1'b0, 1'b0, 8'h02);
    cpu_send(3'd1, 36'h5008, 1'b0, 1'b0, 8'h04);
    cpu_send(3'd1, 36'h500C, 1'b0, 1'b0, 8'h08);
    cpu_send(3'd0, 36'h5010, 1'b0, 1'b0, 8'h0F);
    cpu_send(3'd1, 36'h5010, 1'b0, 1'b0, 8'h03);
    eb(4'b0111, 32'h5000, 4'h1, 1); eb(4'b0111, 32'h5000, 4'h2, 1);
    eb(4'b0111, 32'h5008, 4'h4, 0); eb(4'b0111, 32'h500C, 4'h8, 1);
    eb(4'b0110, 32'h5010, 4'hF, 1); eb(4'b0111, 32'h5010, 4'h3, 1);
    check_out("R7 no collapse, breaks");

    for (int j = 0; j < 3; j++) hub_send(3'd1, AW'(32'h6000 + 4 * j), 1'b0, 1'b0, 8'h0F);
    for (int i = 0; i < 3; i++) eb(4'b0111, 32'h6000 + 4 * i, 4'hF, 1);
    check_out("R9 hub writes single");

    stall = 1;
    for (int i = 0; i < 12; i++) begin
      logic [31:0] a;
      logic [2:0] k;
      a = 32'h00F0 + 4 * i;
      k = (i % 2 == 1) ? 3'd3 : 3'd2;
      cpu_send(k, AW'(a), 1'b0, i == 5, {4'hA, 4'(i + 1)});
      if (a >= 32'h100 && a <= 32'h10C) eb((i % 2 == 1) ? 4'b0011 : 4'b0010, a, 4'(i + 1), 1);
      else exp_f.push_back({k, AW'(a), {4'hA, 4'(i + 1)}, 1'b0, i == 5});
    end
    cpu_send(3'd3, 36'h1_0104, 1'b1, 1'b0, 8'hFF);
    exp_f.push_back({3'd3, 36'h1_0104, 8'hFF, 1'b1, 1'b0});
    hub_send(3'd2, 36'h0200, 1'b0, 1'b0, 8'h0F);
    eb(4'b0010, 32'h0200, 4'hF, 1);
    check_out("R3 io window sweep");

    wr_sweep("R11 R8 stalled qword runs", 1'b1);
    stall = 0;

    cpu_send(3'd4, 36'h8000_0810, 1'b0, 1'b0, 8'h0F);
    hub_send(3'd5, 36'h0001_2344, 1'b0, 1'b1, 8'h03);
    eb(4'b1010, 32'h8000_0811, 4'hF, 1);
    eb(4'b1011, 32'h0001_2345, 4'h3, 1);
    check_out("R5 type1 config");

    cpu_send(3'd1, 36'h1_0000_0000, 1'b0, 1'b0, 8'h0F);
    gap(2);
    hub_send(3'd0, 36'h8_0000_0000, 1'b0, 1'b0, 8'h0F);
    gap(2);
    cpu_send(3'd6, 36'h0000_0100, 1'b0, 1'b0, 8'h0F);
    gap(2);
    cpu_send(3'd1, 36'h7000, 1'b0, 1'b0, 8'h0F);
    cpu_send(3'd1, 36'h1_0000_7004, 1'b0, 1'b0, 8'h0F);
    eb(4'b0111, 32'h7000, 4'hF, 1);
    check_out("R6 rejects");
    check_err("R6 error pulses", 3, 1);

    fork
      cpu_send(3'd0, 36'h9000, 1'b0, 1'b0, 8'h01);
      hub_send(3'd0, 36'h9100, 1'b0, 1'b0, 8'h02);
    join
    eb(4'b0110, 32'h9000, 4'h1, 1); eb(4'b0110, 32'h9100, 4'h2, 1);
    check_out("R10 same-cycle priority");

    fork
      for (int j = 0; j < 3; j++) cpu_send(3'd1, AW'(32'hA000 + 4 * j), 1'b0, 1'b0, 8'h0C);
      hub_send(3'd1, 36'hA100, 1'b0, 1'b0, 8'h06);
    join
    for (int i = 0; i < 3; i++) eb(4'b0111, 32'hA000 + 4 * i, 4'hC, i == 2);
    eb(4'b0111, 32'hA100, 4'h6, 1);
    check_out("R10 hub waits for open burst");
    check_err("R6 no stray errors", 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule